// File: doc/BRIEF.md
# Load and Shift Clock Divider Chain

This block turns a fast clock, already post-scaled, into two slower clocks for a video datapath. The first stage divides the fast clock by one of nine selectable ratios and produces the pixel-load clock. It keeps an exact 50% duty cycle even at the odd ratios. The second stage counts periods of that load clock and divides it by any integer from 1 to 512.

At ratio 1, the second-stage output can act as a gated shift clock. A blanking input, sampled only at load-clock rising boundaries, starts and stops it. While it runs it is edge-for-edge identical to the load clock, and it always stops at a low level.

An active-low enable bit silences both outputs. A restart after that enable is released is aligned, so both clocks begin a fresh period together. An override bit forces the load clock to half the fast clock.

Top module: `ldclk_divchain`

## Requirements
- R1: While `rst_n` is low, `load_clk` and `ld_n2` are both low.
- R2: `n1_sel` codes 0,1,2,3,4,5,6,7,8 select first-stage ratios 3,4,5,6,8,10,12,16,20 in that order, and one `load_clk` period then lasts that many fast-clock cycles.
- R3: For every ratio, odd ones included, `load_clk` is high for exactly half its period; at odd ratios the high and low times are each a whole number of cycles plus one half.
- R4: `n1_sel` codes 9 to 15 select ratio 4.
- R5: With `half_ovr` high, `load_clk` is the fast clock divided by 2 (one cycle high, one low), whatever `n1_sel` holds.
- R6: While `load_off` is 1, both outputs stay low. After `load_off` returns to 0, `load_clk` is still low after the next falling edge, and both outputs rise on the first rising edge that samples `load_off` low.
- R7: The second stage divides `load_clk` by `n2_div`+1. For a ratio M of 2 or more, `ld_n2` rises with `load_clk` and stays high for floor(M/2) `load_clk` periods of the M. For M=1 it follows `load_clk`.
- R8: With `n2_div`=0 and the gate open, `ld_n2` equals `load_clk` at every half cycle (zero skew), odd first-stage ratios included.
- R9: With `sc_en`=1, `blank` is sampled on each fast-clock edge where `load_clk` rises. If that sample is low, `ld_n2` is low from that edge on, and a pulse already in progress completes at full length.
- R10: With `sc_en`=1, if `blank` is sampled high at a `load_clk` rising edge while `ld_n2` is stopped, `ld_n2` stays low until that edge and rises together with `load_clk` there.
- R11: With `sc_en`=0, `blank` has no effect and `ld_n2` keeps dividing.
- R12: A change of `n1_sel` made inside a `load_clk` period does not alter that period. The new ratio applies from the next `load_clk` rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Fast post-scaled input clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_off | input | 1 | Divider enable, active low: 1 silences both outputs |
| half_ovr | input | 1 | Forces the first stage to divide by 2 |
| n1_sel | input | 4 | First-stage ratio code |
| n2_div | input | 9 | Second-stage ratio minus one |
| sc_en | input | 1 | Lets `blank` gate `ld_n2` |
| blank | input | 1 | Gate control, sampled at `load_clk` rising edges |
| load_clk | output | 1 | Pixel-load clock |
| ld_n2 | output | 1 | Second-stage divided clock or gated shift clock |

## Verification
Both outputs may change on either fast-clock edge. Every observation is therefore taken one nanosecond after each edge, and durations are counted in half cycles.

After a release of `load_off`, the rise of both outputs is due on the second sample. That sample follows the first rising edge.

A `blank` or `n1_sel` change takes effect only at the next `load_clk` rise. The checks therefore apply a change at a rise sample, compare the remainder of the current period against the old behaviour, and sample the new behaviour starting at the following rise.

Period measurements always start from an aligned restart, so the scoreboard knows exactly which period is being measured.

// File: rtl/ldclk_divchain.sv
`timescale 1ns/1ps
module ldclk_divchain #(
  parameter int SEL_W = 4,
  parameter int N2_W  = 9,
  parameter int CNT_W = 5
) (
  input  logic             clk_fast,
  input  logic             rst_n,
  input  logic             load_off,
  input  logic             half_ovr,
  input  logic [SEL_W-1:0] n1_sel,
  input  logic [N2_W-1:0]  n2_div,
  input  logic             sc_en,
  input  logic             blank,
  output logic             load_clk,
  output logic             ld_n2
);
  localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);
  localparam logic [CNT_W-1:0] RST_MOD = CNT_W'(4);

  function automatic logic [CNT_W-1:0] ratio_of(input logic [SEL_W-1:0] s);
    case (int'(s))
      0:       return CNT_W'(3);
      1:       return CNT_W'(4);
      2:       return CNT_W'(5);
      3:       return CNT_W'(6);
      4:       return CNT_W'(8);
      5:       return CNT_W'(10);
      6:       return CNT_W'(12);
      7:       return CNT_W'(16);
      8:       return CNT_W'(20);
      default: return CNT_W'(4);
    endcase
  endfunction

  logic [CNT_W-1:0] cnt_q, mod_q, mod_nx, cnt_inc, half_q;
  logic             load_p, load_n, wrap, lp_nx;
  logic [N2_W-1:0]  n2_cnt_q, n2_cnt_nx;
  logic [N2_W:0]    n2_half;
  logic             n2_p, n2_n, gate_q, gate_nx, n2_unit, n2_wrap;

  // stage 1: ratio is latched at each period start
  assign mod_nx  = half_ovr ? CNT_W'(2) : ratio_of(n1_sel);
  assign cnt_inc = cnt_q + ONE;
  assign half_q  = mod_q >> 1;
  assign wrap    = cnt_q >= mod_q - ONE;
  assign lp_nx   = wrap | (cnt_inc < half_q);

  // stage 2 and shift gate
  assign n2_unit   = (n2_div == '0);
  assign n2_wrap   = n2_cnt_q >= n2_div;
  assign n2_cnt_nx = n2_wrap ? '0 : n2_cnt_q + N2_W'(1);
  assign n2_half   = ({1'b0, n2_div} + (N2_W+1)'(1)) >> 1;
  assign gate_nx   = blank | ~sc_en;

  always_ff @(posedge clk_fast or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= RST_MOD - ONE;
      mod_q    <= RST_MOD;
      load_p   <= 1'b0;
      n2_cnt_q <= '1;
      n2_p     <= 1'b0;
      gate_q   <= 1'b0;
    end else if (load_off) begin
      cnt_q    <= mod_q - ONE;
      load_p   <= 1'b0;
      n2_cnt_q <= '1;
      n2_p     <= 1'b0;
      gate_q   <= 1'b0;
    end else if (wrap) begin
      cnt_q    <= '0;
      mod_q    <= mod_nx;
      load_p   <= 1'b1;
      gate_q   <= gate_nx;
      n2_cnt_q <= n2_cnt_nx;
      n2_p     <= gate_nx & (n2_unit | ({1'b0, n2_cnt_nx} < n2_half));
    end else begin
      cnt_q  <= cnt_inc;
      load_p <= lp_nx;
      if (n2_unit) n2_p <= gate_q & lp_nx;
    end
  end

  // half-cycle extension for odd ratios
  always_ff @(negedge clk_fast or negedge rst_n) begin
    if (!rst_n) begin
      load_n <= 1'b0;
      n2_n   <= 1'b0;
    end else begin
      load_n <= load_p & mod_q[0];
      n2_n   <= n2_p & mod_q[0] & n2_unit;
    end
  end

  assign load_clk = load_p | load_n;
  assign ld_n2    = n2_p | n2_n;
endmodule

// File: rtl/ldclk_divchain_chk.sv
`timescale 1ns/1ps
module ldclk_divchain_chk #(
  parameter int N2_W  = 9,
  parameter int CNT_W = 5
) (
  input logic             clk_fast,
  input logic             rst_n,
  input logic             load_off,
  input logic [N2_W-1:0]  n2_div,
  input logic             load_clk,
  input logic             ld_n2,
  input logic [CNT_W-1:0] mod_q,
  input logic             gate_q
);
  AST_RATIO_LEGAL: assert property (@(posedge clk_fast) disable iff (!rst_n)
    (mod_q == CNT_W'(2) || mod_q == CNT_W'(3) || mod_q == CNT_W'(4) || mod_q == CNT_W'(5) ||
     mod_q == CNT_W'(6) || mod_q == CNT_W'(8) || mod_q == CNT_W'(10) || mod_q == CNT_W'(12) ||
     mod_q == CNT_W'(16) || mod_q == CNT_W'(20))) else $error("ratio outside set"); // R2

  AST_OFF_QUIET: assert property (@(posedge clk_fast) disable iff (!rst_n)
    load_off && $past(load_off) |-> !load_clk && !ld_n2) else $error("output active while off"); // R6

  AST_HALF_TOGGLE: assert property (@(posedge clk_fast) disable iff (!rst_n)
    mod_q == CNT_W'(2) && $past(mod_q) == CNT_W'(2) && !load_off && !$past(load_off)
    |-> load_clk != $past(load_clk)) else $error("divide-by-2 not toggling"); // R5

  AST_SHIFT_SKEW: assert property (@(posedge clk_fast) disable iff (!rst_n)
    n2_div == '0 && $past(n2_div) == '0 && gate_q && $past(gate_q)
    |-> ld_n2 == load_clk) else $error("shift clock skewed"); // R8

  AST_GATE_LOW: assert property (@(posedge clk_fast) disable iff (!rst_n)
    !gate_q |-> !ld_n2) else $error("gated clock not low"); // R9
endmodule

bind ldclk_divchain ldclk_divchain_chk #(.N2_W(N2_W), .CNT_W(CNT_W)) u_chk (
  .clk_fast(clk_fast), .rst_n(rst_n), .load_off(load_off), .n2_div(n2_div),
  .load_clk(load_clk), .ld_n2(ld_n2), .mod_q(mod_q), .gate_q(gate_q)
);

// File: tb/ldclk_divchain_test.sv
`timescale 1ns/1ps
module ldclk_divchain_test;
  logic clk = 1'b0, rst_n = 1'b0, load_off = 1'b0, half_ovr = 1'b0, sc_en = 1'b0, blank = 1'b1;
  logic [3:0] n1_sel = 4'd1;
  logic [8:0] n2_div = 9'd0;
  logic load_clk, ld_n2;

  always #2 clk = ~clk; // 250 MHz

  ldclk_divchain uut (
    .clk_fast(clk), .rst_n(rst_n), .load_off(load_off), .half_ovr(half_ovr),
    .n1_sel(n1_sel), .n2_div(n2_div), .sc_en(sc_en), .blank(blank),
    .load_clk(load_clk), .ld_n2(ld_n2)
  );

  typedef struct {string tag; int sel; int hi; int lo; int n;} exp_t;
  exp_t sb[$];
  event kick;
  int checks = 0, errors = 0, issued = 0, served = 0;
  bit fin = 1'b0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic smp();
    @(clk);
    #1;
  endtask

  function automatic logic pick(input int sel);
    return (sel == 0) ? load_clk : ld_n2;
  endfunction

  task automatic wait_rise(input int sel);
    logic p, c;
    p = pick(sel);
    while (1) begin
      smp();
      c = pick(sel);
      if (!p && c) break;
      p = c;
    end
  endtask

  // called at a rise sample, returns at the next rise sample
  task automatic meas(input int sel, output int hi, output int lo);
    hi = 1; smp();
    while (pick(sel)) begin hi++; smp(); end
    lo = 1; smp();
    while (!pick(sel)) begin lo++; smp(); end
  endtask

  task automatic restart();
    load_off = 1'b1;
    repeat (6) smp();
    load_off = 1'b0;
  endtask

  task automatic run_period(input string tag, input int sel, input int hi, input int lo, input int n);
    exp_t e;
    load_off = 1'b1;
    repeat (6) smp();
    e.tag = tag; e.sel = sel; e.hi = hi; e.lo = lo; e.n = n;
    sb.push_back(e);
    issued++;
    ->kick;
    load_off = 1'b0;
    wait (served == issued);
  endtask

  // monitor
  initial forever begin
    exp_t e;
    int hi, lo;
    while (sb.size() == 0) @(kick);
    e = sb.pop_front();
    wait_rise(e.sel);
    for (int k = 0; k < e.n; k++) begin
      meas(e.sel, hi, lo);
      chk(hi == e.hi, e.tag, "high half-cycles", hi, e.hi);
      chk(lo == e.lo, e.tag, "low half-cycles", lo, e.lo);
    end
    served++;
  end

  initial begin
    #800000;
    if (!fin) begin
      fin = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int ratios[9] = '{3, 4, 5, 6, 8, 10, 12, 16, 20};
    int bad, rises, hi, lo;
    logic p;

    repeat (3) smp();
    chk(load_clk == 1'b0, "R1", "load_clk in reset", load_clk, 0);
    chk(ld_n2 == 1'b0, "R1", "ld_n2 in reset", ld_n2, 0);
    rst_n = 1'b1;

    for (int c = 0; c < 9; c++) begin
      n1_sel = 4'(c);
      if (ratios[c] % 2 == 1) run_period("R3", 0, ratios[c], ratios[c], 2);
      else                    run_period("R2", 0, ratios[c], ratios[c], 2);
    end
    n1_sel = 4'd9;  run_period("R4", 0, 4, 4, 2);
    n1_sel = 4'd15; run_period("R4", 0, 4, 4, 2);

    half_ovr = 1'b1;
    n1_sel = 4'd8; run_period("R5", 0, 2, 2, 3);
    n1_sel = 4'd0; run_period("R5", 0, 2, 2, 3);
    half_ovr = 1'b0;

    n1_sel = 4'd1; n2_div = 9'd1;   run_period("R7", 1, 8, 8, 2);
    n1_sel = 4'd0; n2_div = 9'd4;   run_period("R7", 1, 12, 18, 2);
    n1_sel = 4'd0; n2_div = 9'd511; run_period("R7", 1, 1536, 1536, 1);
    n1_sel = 4'd2; n2_div = 9'd0;   run_period("R7", 1, 5, 5, 2);

    // R6 enable off and aligned release
    n1_sel = 4'd1; n2_div = 9'd0; sc_en = 1'b0;
    restart();
    repeat (20) smp();
    load_off = 1'b1;
    repeat (4) smp();
    bad = 0;
    for (int k = 0; k < 40; k++) begin smp(); if (load_clk || ld_n2) bad++; end
    chk(bad == 0, "R6", "active samples while off", bad, 0);
    do smp(); while (clk !== 1'b1);
    load_off = 1'b0;
    smp();
    chk(load_clk == 1'b0, "R6", "load_clk after falling edge", load_clk, 0);
    smp();
    chk(load_clk == 1'b1, "R6", "load_clk on first enabled edge", load_clk, 1);
    chk(ld_n2 == 1'b1, "R6", "ld_n2 on first enabled edge", ld_n2, 1);

    // R11 blank ignored without sc_en
    n1_sel = 4'd0; sc_en = 1'b0; blank = 1'b0;
    restart();
    bad = 0; rises = 0; p = 1'b0;
    for (int k = 0; k < 60; k++) begin
      smp();
      if (ld_n2 != load_clk) bad++;
      if (!p && load_clk) rises++;
      p = load_clk;
    end
    chk(bad == 0, "R11", "ld_n2 mismatches with blank low", bad, 0);
    chk(rises >= 8, "R11", "load_clk rises", rises, 8);

    // R8 zero skew, odd ratios 3 and 5
    sc_en = 1'b1; blank = 1'b1;
    for (int c = 0; c < 3; c += 2) begin
      n1_sel = 4'(c);
      restart();
      bad = 0;
      for (int k = 0; k < 60; k++) begin smp(); if (ld_n2 != load_clk) bad++; end
      chk(bad == 0, "R8", "ld_n2 vs load_clk mismatches", bad, 0);
    end

    // R9 stop at a rise boundary, pulse in progress completes
    wait_rise(0);
    blank = 1'b0;
    bad = 0; p = 1'b1;
    while (1) begin
      smp();
      if (!p && load_clk) break;
      if (ld_n2 != load_clk) bad++;
      p = load_clk;
    end
    chk(bad == 0, "R9", "pulse truncated before boundary", bad, 0);
    chk(ld_n2 == 1'b0, "R9", "ld_n2 at stopping rise", ld_n2, 0);
    bad = 0; rises = 0; p = 1'b1;
    for (int k = 0; k < 40; k++) begin
      smp();
      if (ld_n2) bad++;
      if (!p && load_clk) rises++;
      p = load_clk;
    end
    chk(bad == 0, "R9", "ld_n2 high while stopped", bad, 0);
    chk(rises >= 3, "R9", "load_clk rises while stopped", rises, 3);

    // R10 start at next rise
    wait_rise(0);
    blank = 1'b1;
    bad = 0; p = 1'b1;
    while (1) begin
      smp();
      if (!p && load_clk) break;
      if (ld_n2) bad++;
      p = load_clk;
    end
    chk(bad == 0, "R10", "ld_n2 high before start boundary", bad, 0);
    chk(ld_n2 == 1'b1, "R10", "ld_n2 at starting rise", ld_n2, 1);
    bad = 0;
    for (int k = 0; k < 30; k++) begin smp(); if (ld_n2 != load_clk) bad++; end
    chk(bad == 0, "R10", "ld_n2 vs load_clk after start", bad, 0);

    // R12 ratio change applies at next period
    sc_en = 1'b0; n1_sel = 4'd1;
    restart();
    wait_rise(0);
    n1_sel = 4'd4;
    meas(0, hi, lo);
    chk(hi == 4 && lo == 4, "R12", "current period half-cycles", hi + lo, 8);
    meas(0, hi, lo);
    chk(hi == 8 && lo == 8, "R12", "next period half-cycles", hi + lo, 16);

    if (!fin) begin
      fin = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule